// File: doc/BRIEF.md
# UART Register Front End with Status Flags and Interrupts

This block is the byte-wide register side of an asynchronous serial port. Software reaches it over a small eight-location register bus. Through that bus it sets the frame mode, the bit-rate divisor and the enables, and it writes transmit bytes. It also reads received bytes and the status word. The serial shifters sit outside. The block hands a transmit byte to them with a one-cycle launch strobe. It takes received bytes and break events back in as strobes.

The block keeps four flags and drives four interrupt lines. The flags are transmit-empty, transmit-end, receive-full and a three-flag error field. The interrupts are transmit and receive, which are one-cycle pulses, and transmit-end and error, which are levels. An external frame timer reports the end of each transmitted frame. For receive, the block itself holds off the receiver for one frame time after each accepted byte. That frame time is derived from the mode and bit-rate registers.

Top module: `uart_regfront`

## Requirements
- R1: After reset, mode and control read 0x00, bit rate reads 0xFF, status reads 0x84 and all four interrupt outputs are low.
- R2: Offsets are mode 0, bit rate 1, control 2, transmit data 3, status 4, receive data 5, extension 6 and 7. The extension registers read back what was written. Status bits are transmit-empty 7, receive-full 6, error field 5:3 (overrun 5, framing 4, parity 3), transmit-end 2 and the multiprocessor bit 0. Control bits are transmit interrupt enable 7, receive interrupt enable 6, transmit enable 5, receive enable 4 and transmit-end interrupt enable 2.
- R3: A control write whose new value has transmit enable set makes transmit-empty and transmit-end 1. It pulses the transmit interrupt for one cycle if the new value enables it.
- R4: A control write whose new value clears the transmit-end interrupt enable drops that interrupt. One whose new value clears the receive interrupt enable drops the error interrupt.
- R5: A transmit-data write while transmit-end is 1 launches the byte. It gives a one-cycle launch strobe with the byte, clears transmit-end, sets transmit-empty, drops the transmit-end interrupt and pulses the transmit interrupt if enabled.
- R6: A transmit-data write while transmit-end is 0 only clears transmit-empty. There is no launch and no interrupt.
- R7: A frame-done strobe while transmit-empty is 1 sets transmit-end and raises the transmit-end interrupt level if it is enabled. A strobe while transmit-empty is 0 changes nothing.
- R8: A byte accepted while receive-full is 0 is stored, sets receive-full and pulses the receive interrupt if enabled. A byte accepted while receive-full is 1 sets overrun, raises the error interrupt if enabled and leaves the stored byte unchanged.
- R9: Reading receive data clears receive-full. Writes to that offset are ignored.
- R10: A status write sets the multiprocessor bit from data bit 0 and ANDs the error field with data bits 5:3. No other status bit changes.
- R11: If the last status read showed a nonzero error field, a status write that leaves the field zero drops the error interrupt.
- R12: Mode and bit-rate writes take effect only while transmit enable and receive enable are both 0.
- R13: A break strobe sets the framing flag and raises the error interrupt if receive interrupts are enabled.
- R14: The ready output is high only when receive enable is 1 and one frame time has passed since the last accepted byte. The frame time in cycles is (10 - mode bit 6 + mode bit 5 + mode bit 3) * (bit rate + 1) * 4^(mode bits 1:0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| tx_launch | output | 1 | One-cycle strobe: byte handed to shifter, frame timer starts |
| tx_byte | output | 8 | Byte being launched |
| frame_done | input | 1 | Frame timer expiry strobe |
| rx_valid | input | 1 | Receiver offers a byte |
| rx_byte | input | 8 | Offered byte |
| rx_ready | output | 1 | Byte will be accepted this cycle |
| rx_break | input | 1 | Break detected strobe |
| irq_txi | output | 1 | Transmit interrupt pulse |
| irq_rxi | output | 1 | Receive interrupt pulse |
| irq_tei | output | 1 | Transmit-end interrupt level |
| irq_eri | output | 1 | Error interrupt level |

## Verification
The assertions assume that a status write is not accompanied by a byte acceptance or a break in the same cycle; otherwise the error field may legitimately gain a flag. They also assume that only one bus access happens per cycle, and that rx_valid counts only together with rx_ready. The stimulus applies each event on its own cycle. It offers bytes only when the ready output is high. It never overlaps a receive-data read with a byte arrival.

// File: rtl/urf_pkg.sv
package urf_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned DATA_W = 8;

  typedef enum logic [ADDR_W-1:0] {
    OFS_MODE = 3'd0, OFS_RATE = 3'd1, OFS_CTRL = 3'd2, OFS_TXD = 3'd3,
    OFS_STAT = 3'd4, OFS_RXD  = 3'd5, OFS_EXT0 = 3'd6, OFS_EXT1 = 3'd7
  } reg_ofs_e;

  // control bits
  localparam int unsigned C_TIE  = 7;
  localparam int unsigned C_RIE  = 6;
  localparam int unsigned C_TE   = 5;
  localparam int unsigned C_RE   = 4;
  localparam int unsigned C_TEIE = 2;

  // mode bits
  localparam int unsigned M_SHORT = 6;
  localparam int unsigned M_PAR   = 5;
  localparam int unsigned M_STOP2 = 3;

  // frame length in clock cycles
  function automatic int unsigned frame_cycles(input logic [7:0] mode, input logic [7:0] rate);
    int unsigned nbits;
    int unsigned base;
    nbits = 32'd10 - {31'd0, mode[M_SHORT]} + {31'd0, mode[M_PAR]} + {31'd0, mode[M_STOP2]};
    base  = nbits * ({24'd0, rate} + 32'd1);
    return base << {mode[1:0], 1'b0};
  endfunction
endpackage

// File: rtl/urf_guard.sv
module urf_guard #(
  parameter int unsigned CNT_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] load_val,
  output logic             idle
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt_q <= '0;
    else if (start)      cnt_q <= load_val;
    else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign idle = (cnt_q == '0);
endmodule

// File: rtl/urf_txctl.sv
module urf_txctl #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctrl_wr,
  input  logic          new_te,
  input  logic          new_tie,
  input  logic          new_teie,
  input  logic          tie_q,
  input  logic          teie_q,
  input  logic          txd_wr,
  input  logic [DW-1:0] wdata,
  input  logic          frame_done,
  output logic          tdre,
  output logic          tend,
  output logic [DW-1:0] tdr_q,
  output logic          tx_launch,
  output logic [DW-1:0] tx_byte,
  output logic          irq_txi,
  output logic          irq_tei
);
  logic launch_now;
  assign launch_now = txd_wr && tend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tdre <= 1'b1; tend <= 1'b1; tdr_q <= '0; tx_byte <= '0;
      tx_launch <= 1'b0; irq_txi <= 1'b0; irq_tei <= 1'b0;
    end else begin
      tx_launch <= 1'b0;
      irq_txi   <= 1'b0;
      if (frame_done && tdre) begin
        tend <= 1'b1;
        if (teie_q) irq_tei <= 1'b1;
      end
      if (ctrl_wr) begin
        if (!new_teie) irq_tei <= 1'b0;
        if (new_te) begin
          tdre <= 1'b1;
          tend <= 1'b1;
          irq_txi <= new_tie;
        end
      end
      if (txd_wr) begin
        tdr_q <= wdata;
        if (launch_now) begin
          tend <= 1'b0; tdre <= 1'b1; irq_tei <= 1'b0;
          irq_txi <= tie_q; tx_launch <= 1'b1; tx_byte <= wdata;
        end else begin
          tdre <= 1'b0;
        end
      end
    end
  end

  a_r5_launch_leaves_empty: assert property (@(posedge clk) disable iff (!rst_n)
    tx_launch |-> (tdre && !tend));
  a_r7_tend_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tend) |-> $past(frame_done || (ctrl_wr && new_te)));
endmodule

// File: rtl/urf_rxctl.sv
module urf_rxctl #(
  parameter int unsigned DW    = 8,
  parameter int unsigned CNT_W = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          re_q,
  input  logic          rie_q,
  input  logic          ctrl_wr,
  input  logic          new_rie,
  input  logic [7:0]    mode_q,
  input  logic [7:0]    rate_q,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_byte,
  input  logic          rx_break,
  input  logic          rxd_rd,
  input  logic          stat_rd,
  input  logic          stat_wr,
  input  logic [DW-1:0] wdata,
  output logic          rdrf,
  output logic [2:0]    err,
  output logic          mpb,
  output logic [DW-1:0] rdr_q,
  output logic          rx_ready,
  output logic          irq_rxi,
  output logic          irq_eri
);
  import urf_pkg::*;

  logic             guard_idle;
  logic             rx_accept;
  logic [2:0]       snap_err;
  logic [2:0]       err_masked;
  logic [CNT_W-1:0] guard_load;

  assign rx_ready   = re_q && guard_idle;
  assign rx_accept  = rx_valid && rx_ready;
  assign err_masked = err & wdata[5:3];
  assign guard_load = CNT_W'(frame_cycles(mode_q, rate_q) - 32'd1);

  urf_guard #(.CNT_W(CNT_W)) guard_i (
    .clk(clk), .rst_n(rst_n), .start(rx_accept), .load_val(guard_load), .idle(guard_idle)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdrf <= 1'b0; err <= '0; mpb <= 1'b0; rdr_q <= '0; snap_err <= '0;
      irq_rxi <= 1'b0; irq_eri <= 1'b0;
    end else begin
      irq_rxi <= 1'b0;
      if (stat_rd) snap_err <= err;
      if (rxd_rd)  rdrf <= 1'b0;
      if (ctrl_wr && !new_rie) irq_eri <= 1'b0;
      if (stat_wr) begin
        mpb <= wdata[0];
        err <= err_masked;
        if (snap_err != 3'd0 && err_masked == 3'd0) irq_eri <= 1'b0;
      end
      if (rx_accept) begin
        if (rdrf) begin
          err[2] <= 1'b1;
          if (rie_q) irq_eri <= 1'b1;
        end else begin
          rdr_q <= rx_byte;
          rdrf  <= 1'b1;
          irq_rxi <= rie_q;
        end
      end
      if (rx_break) begin
        err[1] <= 1'b1;
        if (rie_q) irq_eri <= 1'b1;
      end
    end
  end

  a_r10_err_never_set_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && !rx_accept && !rx_break) |=> ((err & ~$past(err)) == 3'd0));
  a_r8_full_needs_accept: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdrf) |-> $past(rx_accept));
  a_r14_guard_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    rx_accept |=> !rx_ready);
endmodule

// File: rtl/uart_regfront.sv
module uart_regfront #(
  parameter int unsigned CNT_W = 18
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_sel,
  input  logic       bus_wr,
  input  logic [2:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       tx_launch,
  output logic [7:0] tx_byte,
  input  logic       frame_done,
  input  logic       rx_valid,
  input  logic [7:0] rx_byte,
  output logic       rx_ready,
  input  logic       rx_break,
  output logic       irq_txi,
  output logic       irq_rxi,
  output logic       irq_tei,
  output logic       irq_eri
);
  import urf_pkg::*;

  logic [7:0] mode_q, rate_q, ctrl_q, ext0_q, ext1_q, tdr_q, rdr_q;
  logic       wr_any, rd_any, cfg_open;
  logic       ctrl_wr, txd_wr, stat_wr, stat_rd, rxd_rd;
  logic       tdre, tend, rdrf, mpb;
  logic [2:0] err;
  logic [7:0] stat_word;

  assign wr_any   = bus_sel && bus_wr;
  assign rd_any   = bus_sel && !bus_wr;
  assign cfg_open = !ctrl_q[C_TE] && !ctrl_q[C_RE];
  assign ctrl_wr  = wr_any && (bus_addr == OFS_CTRL);
  assign txd_wr   = wr_any && (bus_addr == OFS_TXD);
  assign stat_wr  = wr_any && (bus_addr == OFS_STAT);
  assign stat_rd  = rd_any && (bus_addr == OFS_STAT);
  assign rxd_rd   = rd_any && (bus_addr == OFS_RXD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= 8'h00; rate_q <= 8'hFF; ctrl_q <= 8'h00; ext0_q <= 8'h00; ext1_q <= 8'h00;
    end else if (wr_any) begin
      unique case (bus_addr)
        OFS_MODE: if (cfg_open) mode_q <= bus_wdata;
        OFS_RATE: if (cfg_open) rate_q <= bus_wdata;
        OFS_CTRL: ctrl_q <= bus_wdata;
        OFS_EXT0: ext0_q <= bus_wdata;
        OFS_EXT1: ext1_q <= bus_wdata;
        default: ;
      endcase
    end
  end

  urf_txctl #(.DW(8)) tx_i (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr),
    .new_te(bus_wdata[C_TE]), .new_tie(bus_wdata[C_TIE]), .new_teie(bus_wdata[C_TEIE]),
    .tie_q(ctrl_q[C_TIE]), .teie_q(ctrl_q[C_TEIE]),
    .txd_wr(txd_wr), .wdata(bus_wdata), .frame_done(frame_done),
    .tdre(tdre), .tend(tend), .tdr_q(tdr_q), .tx_launch(tx_launch), .tx_byte(tx_byte),
    .irq_txi(irq_txi), .irq_tei(irq_tei)
  );

  urf_rxctl #(.DW(8), .CNT_W(CNT_W)) rx_i (
    .clk(clk), .rst_n(rst_n), .re_q(ctrl_q[C_RE]), .rie_q(ctrl_q[C_RIE]),
    .ctrl_wr(ctrl_wr), .new_rie(bus_wdata[C_RIE]), .mode_q(mode_q), .rate_q(rate_q),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_break(rx_break),
    .rxd_rd(rxd_rd), .stat_rd(stat_rd), .stat_wr(stat_wr), .wdata(bus_wdata),
    .rdrf(rdrf), .err(err), .mpb(mpb), .rdr_q(rdr_q), .rx_ready(rx_ready),
    .irq_rxi(irq_rxi), .irq_eri(irq_eri)
  );

  assign stat_word = {tdre, rdrf, err, tend, 1'b0, mpb};

  always_comb begin
    unique case (bus_addr)
      OFS_MODE: bus_rdata = mode_q;
      OFS_RATE: bus_rdata = rate_q;
      OFS_CTRL: bus_rdata = ctrl_q;
      OFS_TXD:  bus_rdata = tdr_q;
      OFS_STAT: bus_rdata = stat_word;
      OFS_RXD:  bus_rdata = rdr_q;
      OFS_EXT0: bus_rdata = ext0_q;
      default:  bus_rdata = ext1_q;
    endcase
  end

  a_r12_mode_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_any && bus_addr == OFS_MODE && !cfg_open) |=> $stable(mode_q));
  a_r12_rate_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_any && bus_addr == OFS_RATE && !cfg_open) |=> $stable(rate_q));
endmodule

// File: tb/uart_regfront_tb_top.sv
module uart_regfront_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 0, bus_wr = 0, frame_done = 0, rx_valid = 0, rx_break = 0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, rx_byte = '0;
  logic [7:0] bus_rdata, tx_byte;
  logic tx_launch, rx_ready, irq_txi, irq_rxi, irq_tei, irq_eri;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic s_txi, s_rxi, s_launch;
  logic [7:0] s_txb;

  always #2 clk = ~clk;

  uart_regfront dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_launch(tx_launch), .tx_byte(tx_byte),
    .frame_done(frame_done), .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_ready(rx_ready),
    .rx_break(rx_break), .irq_txi(irq_txi), .irq_rxi(irq_rxi), .irq_tei(irq_tei), .irq_eri(irq_eri)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    tests++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // monitor: compares read data against the scoreboard queue
  always begin
    @(negedge clk); #1;
    if (bus_sel && !bus_wr) begin
      if (exp_q.size() == 0) check("R2 unexpected read", 32'd1, 32'd0);
      else check(tag_q.pop_front(), {24'd0, bus_rdata}, {24'd0, exp_q.pop_front()});
    end
  end

  task automatic snap();
    s_txi = irq_txi; s_rxi = irq_rxi; s_launch = tx_launch; s_txb = tx_byte;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); snap(); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] e, input string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk); bus_sel = 0;
  endtask

  task automatic frame();
    @(negedge clk); frame_done = 1;
    @(negedge clk); snap(); frame_done = 0;
  endtask

  task automatic rxsend(input logic [7:0] b);
    @(negedge clk); rx_valid = 1; rx_byte = b;
    @(negedge clk); snap(); rx_valid = 0;
  endtask

  task automatic brk();
    @(negedge clk); rx_break = 1;
    @(negedge clk); snap(); rx_break = 0;
  endtask

  function automatic int fcyc(input logic [7:0] m, input logic [7:0] r);
    return (10 - m[6] + m[5] + m[3]) * (r + 1) * (4 ** m[1:0]);
  endfunction

  task automatic guard_count(input int expn, input string tag);
    int n = 0;
    while (!rx_ready && n < 100000) begin @(negedge clk); n++; end
    check(tag, n, expn);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    fails++; tests++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check("R1 irq lines", {irq_txi, irq_rxi, irq_tei, irq_eri}, 4'b0);
    rd(0, 8'h00, "R1 mode reset"); rd(1, 8'hFF, "R1 rate reset");
    rd(2, 8'h00, "R1 ctrl reset"); rd(4, 8'h84, "R1 status reset");
    // R2 extension registers
    wr(6, 8'h5A); wr(7, 8'hC3);
    rd(6, 8'h5A, "R2 ext0"); rd(7, 8'hC3, "R2 ext1");
    // R12 open while disabled
    wr(0, 8'h00); wr(1, 8'h00);
    rd(1, 8'h00, "R12 rate written when disabled");
    // R3 enable transmit
    wr(2, 8'hF4);
    check("R3 txi pulse", s_txi, 1);
    rd(4, 8'h84, "R3 empty and end set");
    // R12 locked while enabled
    wr(0, 8'h45); wr(1, 8'h33);
    rd(0, 8'h00, "R12 mode locked"); rd(1, 8'h00, "R12 rate locked");
    // R5 immediate launch
    wr(3, 8'hA5);
    check("R5 launch", s_launch, 1); check("R5 byte", s_txb, 8'hA5); check("R5 txi", s_txi, 1);
    rd(4, 8'h80, "R5 end cleared");
    // R7 frame done with empty set
    frame();
    check("R7 tei level", irq_tei, 1);
    rd(4, 8'h84, "R7 end set");
    // R4 clear transmit-end interrupt enable
    wr(2, 8'hF0);
    check("R4 tei dropped", irq_tei, 0);
    wr(3, 8'h3C);
    check("R5 second launch", s_launch, 1);
    // R6 write while end is 0
    wr(3, 8'h11);
    check("R6 no launch", s_launch, 0); check("R6 no txi", s_txi, 0);
    rd(4, 8'h00, "R6 empty cleared");
    // R7 frame done ignored when empty is 0
    frame();
    rd(4, 8'h00, "R7 ignored"); check("R7 tei low", irq_tei, 0);
    // R8 receive
    check("R14 ready when enabled", rx_ready, 1);
    rxsend(8'h5E);
    check("R8 rxi pulse", s_rxi, 1);
    check("R14 busy after accept", rx_ready, 0);
    guard_count(fcyc(8'h00, 8'h00) - 1, "R14 frame time 10");
    rd(4, 8'h40, "R8 full set");
    rxsend(8'h77);
    check("R8 overrun eri", irq_eri, 1); check("R8 no rxi on overrun", s_rxi, 0);
    rd(4, 8'h60, "R8 overrun flag");
    // R9
    rd(5, 8'h5E, "R8 byte kept");
    wr(5, 8'hFF);
    rd(5, 8'h5E, "R9 write ignored");
    // R11 snapshot then clear
    rd(4, 8'h20, "R9 full cleared");
    wr(4, 8'h00);
    check("R11 eri dropped", irq_eri, 0);
    rd(4, 8'h00, "R11 field clear");
    // R13 break, R10 masked write
    brk();
    check("R13 eri", irq_eri, 1);
    rd(4, 8'h10, "R13 framing flag");
    wr(4, 8'hFD);
    rd(4, 8'h11, "R10 and-mask and mpb");
    check("R11 eri kept nonzero", irq_eri, 1);
    // R4 clear receive interrupt enable
    wr(2, 8'hB0);
    check("R4 eri dropped", irq_eri, 0); check("R3 txi on rewrite", s_txi, 1);
    rd(4, 8'h95, "R3 flags on rewrite");
    // R14 with slower frame
    wr(2, 8'h00); wr(0, 8'h01); wr(1, 8'h01);
    rd(0, 8'h01, "R12 mode open"); rd(1, 8'h01, "R12 rate open");
    check("R14 not ready when disabled", rx_ready, 0);
    wr(2, 8'h50);
    rxsend(8'h99);
    check("R8 rxi enabled", s_rxi, 1);
    guard_count(fcyc(8'h01, 8'h01) - 1, "R14 frame time 80");
    rd(5, 8'h99, "R8 second byte");
    repeat (4) @(negedge clk);
    finish_up();
  end
endmodule